// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock of an SD/MMC host from a faster base clock. The division has two stages. A power-of-two prescaler comes first, and a linear divisor follows it. The card clock period is the prescaler ratio times the divisor, counted in base clock cycles. Software loads both fields with a single write strobe. Two enables gate the output: a card clock enable and a peripheral clock enable.

The block drives two outputs. The first is a toggling card clock, high for the first half of each period. The second is a one-cycle tick in the base clock domain, given once per card period. The clock is gated so that it starts and stops without runt pulses. A stable flag shows when a full period has run at the current setting. The intended software sequence is to drop the card enable, write the fields, wait for the stable flag, and then enable the clock again. The identification phase of a card typically runs near 400 kHz. The block does not choose the divider values for a target frequency.

Top module: `sdclk_divider`

## Requirements
- R1: While reset is asserted, card_clk_o, card_tick_o and clk_stable_o are low. After reset the fields act as prescale 0 and divisor code 0, which gives a period of one base cycle, and clk_stable_o goes high within six cycles of reset release.
- R2: The prescale field is 8 bits. A value of zero gives a ratio of 1. Otherwise the highest set bit k gives a ratio of 2^(k+1), so 0x01 divides by 2, 0x80 divides by 256, and 0x06 divides by 8.
- R3: The divisor field is 4 bits and holds the divisor minus one, so the divisor runs from 1 to 16.
- R4: While enabled, card_tick_o pulses once every N base cycles, where N is the prescaler ratio times the divisor.
- R5: For N of 2 or more, card_clk_o has a period of N cycles and is high for floor(N/2) cycles of each period. For N = 1, card_clk_o stays low.
- R6: The card clock runs only while both card_clk_en and periph_clk_en are high. If either is low, card_clk_o stays low and no tick is produced.
- R7: A change of either enable takes effect only during the low phase of the internal clock. Every high pulse of card_clk_o therefore has its full width, including the last pulse after a disable.
- R8: A field write restarts both counters. clk_stable_o is low in the cycle after the write edge. It stays low through the next N-1 edges and goes high at the Nth edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_wr | input | 1 | Write strobe that loads both fields |
| cfg_prescale | input | 8 | Prescale field, half the power-of-two ratio |
| cfg_divisor | input | 4 | Divisor minus one |
| card_clk_en | input | 1 | Card clock enable |
| periph_clk_en | input | 1 | Peripheral clock enable |
| card_clk_o | output | 1 | Gated card clock |
| card_tick_o | output | 1 | One-cycle pulse per card clock period |
| clk_stable_o | output | 1 | A full period has elapsed at the current setting |

## Verification
The assertions assume that software changes the fields only while the clock is disabled and the output has settled low. Under that assumption, a rising card clock always comes after the stable flag. The assertions also assume that the counters stay inside the range of the latched fields. The stimulus follows the same rule: it drops the card enable and waits several periods before each write. Every enable change falls at an arbitrary phase, so the bench also covers enables that land during what would be a high phase.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int DEF_PRE_W = 8;
  localparam int DEF_DIV_W = 4;

  typedef enum logic {
    GATE_OFF = 1'b0,
    GATE_ON  = 1'b1
  } gate_e;
endpackage

// File: rtl/sdclk_field_decode.sv
module sdclk_field_decode #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4,
  parameter int SH_W  = $clog2(PRE_W + 1),
  parameter int PH_W  = PRE_W + DIV_W
) (
  input  logic [PRE_W-1:0] pre_fld,
  input  logic [DIV_W-1:0] div_fld,
  output logic [SH_W-1:0]  shift_o,
  output logic [PRE_W-1:0] pre_last_o,
  output logic [PH_W-1:0]  half_o
);
  logic [PRE_W:0] ratio;
  logic [PH_W:0]  n_tot;

  // highest set bit wins; zero means no prescale
  always_comb begin
    shift_o = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (pre_fld[i]) shift_o = SH_W'(i + 1);
    end
  end

  always_comb begin
    ratio      = (PRE_W+1)'(1) << shift_o;
    pre_last_o = PRE_W'(ratio - (PRE_W+1)'(1));
    n_tot      = ((PH_W+1)'(div_fld) + (PH_W+1)'(1)) << shift_o;
    half_o     = n_tot[PH_W:1];
  end
endmodule

// File: rtl/sdclk_prescaler.sv
module sdclk_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign wrap_o = (cnt_q == last);
  assign cnt_o  = cnt_q;

  always_comb begin
    if (clr)         cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else             cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  pre_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
endmodule

// File: rtl/sdclk_divisor.sv
module sdclk_divisor #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_last;

  assign at_last = (cnt_q == last);
  assign wrap_o  = step && at_last;
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (step)    cnt_d = at_last ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  div_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate
  import sdclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic en_req,
  input  logic wrap,
  output logic clk_o,
  output logic tick_o
);
  gate_e gate_q, gate_d;
  logic  clk_q, clk_d, tick_q, tick_d;

  always_comb begin
    gate_d = gate_q;
    if (!lvl) gate_d = en_req ? GATE_ON : GATE_OFF;
    clk_d  = (gate_q == GATE_ON) && lvl;
    tick_d = (gate_q == GATE_ON) && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= GATE_OFF;
      clk_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
      clk_q  <= clk_d;
      tick_q <= tick_d;
    end
  end

  assign clk_o  = clk_q;
  assign tick_o = tick_q;

  // R7
  fall_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_o) |-> !$past(lvl));

  // R7
  rise_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_o) |-> !$past(lvl, 2));
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int PRE_W = DEF_PRE_W,
  parameter int DIV_W = DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic             card_clk_en,
  input  logic             periph_clk_en,
  output logic             card_clk_o,
  output logic             card_tick_o,
  output logic             clk_stable_o
);
  localparam int SH_W = $clog2(PRE_W + 1);
  localparam int PH_W = PRE_W + DIV_W;

  logic [1:0]       rst_sync_q;
  logic             rst_i;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             stable_q, stable_d;
  logic [SH_W-1:0]  shift;
  logic [PRE_W-1:0] pre_last, pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [PH_W-1:0]  half, phase;
  logic             pre_wrap, full_wrap, lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  always_comb begin
    pre_d    = cfg_wr ? cfg_prescale : pre_q;
    div_d    = cfg_wr ? cfg_divisor  : div_q;
    stable_d = stable_q;
    if (cfg_wr)         stable_d = 1'b0;
    else if (full_wrap) stable_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      pre_q    <= '0;
      div_q    <= '0;
      stable_q <= 1'b0;
    end else begin
      pre_q    <= pre_d;
      div_q    <= div_d;
      stable_q <= stable_d;
    end
  end

  sdclk_field_decode #(.PRE_W(PRE_W), .DIV_W(DIV_W), .SH_W(SH_W), .PH_W(PH_W)) dec_i (
    .pre_fld(pre_q), .div_fld(div_q),
    .shift_o(shift), .pre_last_o(pre_last), .half_o(half)
  );

  sdclk_prescaler #(.W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_i), .clr(cfg_wr), .last(pre_last),
    .cnt_o(pre_cnt), .wrap_o(pre_wrap)
  );

  sdclk_divisor #(.W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_i), .clr(cfg_wr), .step(pre_wrap), .last(div_q),
    .cnt_o(div_cnt), .wrap_o(full_wrap)
  );

  assign phase = (PH_W'(div_cnt) << shift) | PH_W'(pre_cnt);
  assign lvl   = (phase < half);

  sdclk_gate gate_i (
    .clk(clk), .rst_n(rst_i), .lvl(lvl),
    .en_req(card_clk_en && periph_clk_en), .wrap(full_wrap),
    .clk_o(card_clk_o), .tick_o(card_tick_o)
  );

  assign clk_stable_o = stable_q;

  // R8
  stable_drop_chk: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_wr |=> !clk_stable_o);

  // R8
  rise_when_stable_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(card_clk_o) |-> clk_stable_o);
endmodule

// File: tb/sdclk_divider_tb.sv
module sdclk_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_prescale;
  logic [3:0] cfg_divisor;
  logic       card_clk_en, periph_clk_en;
  logic       card_clk_o, card_tick_o, clk_stable_o;

  int n_checks = 0;
  int n_errors = 0;
  int exp_q[$];
  int exp_n  = 0;
  int exp_hi = 0;
  string hi_tag = "R5";
  int rise_cnt = 0, tick_cnt = 0, high_cnt = 0;
  logic prev_clk = 1'b0;
  int hi_run = 0, since_rise = 0, since_tick = 0;
  bit have_rise = 0, have_tick = 0;

  always #5 clk = ~clk;

  sdclk_divider dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_prescale(cfg_prescale),
    .cfg_divisor(cfg_divisor), .card_clk_en(card_clk_en),
    .periph_clk_en(periph_clk_en), .card_clk_o(card_clk_o),
    .card_tick_o(card_tick_o), .clk_stable_o(clk_stable_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected periods, checks high widths and tick spacing
  always @(negedge clk) begin
    if (!rst_n) begin
      have_rise = 0; have_tick = 0; hi_run = 0; prev_clk = 1'b0;
    end else begin
      since_rise++;
      since_tick++;
      if (card_clk_o) begin
        hi_run++;
        high_cnt++;
      end else if (hi_run > 0) begin
        chk(hi_run == exp_hi, hi_tag, hi_run, exp_hi);
        hi_run = 0;
      end
      if (card_clk_o && !prev_clk) begin
        rise_cnt++;
        if (have_rise && exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          chk(since_rise == e, "R4 period", since_rise, e);
        end
        have_rise = 1;
        since_rise = 0;
      end
      if (card_tick_o) begin
        tick_cnt++;
        if (have_tick && exp_n > 0)
          chk(since_tick == exp_n, "R4 tick", since_tick, exp_n);
        have_tick = 1;
        since_tick = 0;
      end
      if (!card_clk_en || !periph_clk_en) begin
        have_rise = 0;
        have_tick = 0;
      end
      prev_clk = card_clk_o;
    end
  end

  task automatic write_fields(input logic [7:0] p, input logic [3:0] d, input int n);
    @(negedge clk);
    cfg_prescale = p; cfg_divisor = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(clk_stable_o == 1'b0, "R8 drop", clk_stable_o, 0);
    repeat (n - 1) @(negedge clk);
    chk(clk_stable_o == 1'b0, "R8 still low", clk_stable_o, 0);
    @(negedge clk);
    chk(clk_stable_o == 1'b1, "R8 rise at N", clk_stable_o, 1);
  endtask

  task automatic run_setting(input logic [7:0] p, input logic [3:0] d,
                             input int n, input int hi, input int periods);
    write_fields(p, d, n);
    exp_n = n; exp_hi = hi; hi_tag = "R5 high";
    for (int i = 0; i < periods; i++) exp_q.push_back(n);
    card_clk_en = 1'b1; periph_clk_en = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    card_clk_en = 1'b0;
    repeat (3 * n + 4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog R4 act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int r0, t0, h0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_prescale = '0; cfg_divisor = '0;
    card_clk_en = 1'b0; periph_clk_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(card_clk_o == 0 && card_tick_o == 0, "R1 outputs in reset", card_clk_o, 0);
    chk(clk_stable_o == 0, "R1 stable in reset", clk_stable_o, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(clk_stable_o == 1, "R1 stable after reset", clk_stable_o, 1);

    // R6: peripheral enable low keeps the clock off
    write_fields(8'h01, 4'd2, 6);
    card_clk_en = 1'b1;
    r0 = rise_cnt; t0 = tick_cnt;
    repeat (30) @(negedge clk);
    chk(rise_cnt == r0, "R6 no clock", rise_cnt - r0, 0);
    chk(tick_cnt == t0, "R6 no tick", tick_cnt - t0, 0);
    card_clk_en = 1'b0;
    periph_clk_en = 1'b1;
    r0 = rise_cnt;
    repeat (30) @(negedge clk);
    chk(rise_cnt == r0, "R6 card enable low", rise_cnt - r0, 0);
    periph_clk_en = 1'b0;

    run_setting(8'h01, 4'd2, 6, 3, 4);    // R2 ratio 2, R3 divisor 3
    run_setting(8'h00, 4'd4, 5, 2, 4);    // R2 zero field, odd period
    run_setting(8'h01, 4'd0, 2, 1, 4);    // R5 smallest toggling period
    run_setting(8'h06, 4'd1, 16, 8, 3);   // R2 highest set bit wins
    run_setting(8'h03, 4'd15, 64, 32, 2); // R3 largest divisor
    run_setting(8'h80, 4'd0, 256, 128, 2);// R2 largest prescale

    // R7: disable in the middle of a high pulse keeps its full width
    write_fields(8'h06, 4'd1, 16);
    exp_n = 16; exp_hi = 8; hi_tag = "R7 last pulse";
    card_clk_en = 1'b1; periph_clk_en = 1'b1;
    while (card_clk_o !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    card_clk_en = 1'b0;
    repeat (10) @(negedge clk);
    r0 = rise_cnt;
    repeat (48) @(negedge clk);
    chk(rise_cnt == r0, "R7 stopped", rise_cnt - r0, 0);
    chk(card_clk_o == 0, "R7 held low", card_clk_o, 0);

    // R5/R4 with N = 1: tick every cycle, clock stays low
    write_fields(8'h00, 4'd0, 1);
    exp_n = 1;
    card_clk_en = 1'b1;
    repeat (4) @(negedge clk);
    t0 = tick_cnt; h0 = high_cnt;
    repeat (20) @(negedge clk);
    chk(tick_cnt - t0 == 20, "R4 ticks at N=1", tick_cnt - t0, 20);
    chk(high_cnt == h0, "R5 low at N=1", high_cnt - h0, 0);
    card_clk_en = 1'b0;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule